// File: doc/BRIEF.md
# Power-Fail Time-Stamp Capture

This block records when the main supply went away and when it came back. An external comparator gives a digital supply-good level. The block brings that level into the clock domain and tracks it with a small sequencer. At each supply transition it copies the live calendar time from a running clock core into one of two four-byte snapshot sets. One set holds the power-down moment and the other holds the power-up moment. Each set stores minutes, hours, date and month as BCD bytes, taken from the clock core without change.

A sticky battery-mode flag is set at every switch to backup power. Software reads the flag over a simple register bus and clears it by writing zero to its bit. That write also wipes both snapshot sets. No snapshot is taken while the oscillator-running input is low. From the moment the sequencer leaves main-power operation until it returns, every host read or write is refused.

The sequencer has four states:
- `S_MAIN`: running on main power.
- `S_CAP_DOWN`: one cycle that captures the power-down time and sets the flag.
- `S_BATT`: running on backup power.
- `S_CAP_UP`: one cycle that captures the power-up time.

It has four transitions:
- `S_MAIN` to `S_CAP_DOWN` when the synchronised supply-good is low.
- `S_CAP_DOWN` to `S_BATT` unconditionally.
- `S_BATT` to `S_CAP_UP` when the synchronised supply-good is high.
- `S_CAP_UP` to `S_MAIN` unconditionally.

Top module: `pwr_stamp_top`

## Requirements
- R1: After reset the battery-mode flag is 0, all eight snapshot bytes read 0x00, and host access is open (`on_batt_o` = 0). The reset state treats the supply as good.
- R2: A fall of `supply_good_i` copies the live time into the power-down set. The bytes land at addresses 0x18, 0x19, 0x1A and 0x1B, holding minutes, hours, date and month in that order.
- R3: Every switch to backup power sets the battery-mode flag, whether or not the oscillator runs. The flag is bit 4 of address 0x03, so a read of 0x03 returns 0x10 when it is set. All other bits of 0x03 read 0.
- R4: A rise of `supply_good_i` copies the live time into the power-up set. The bytes land at addresses 0x1C to 0x1F, in the same byte order as R2.
- R5: A host write to 0x03 with bit 4 = 0 clears the flag and all eight snapshot bytes. A write to 0x03 with bit 4 = 1 changes neither the flag nor the snapshots.
- R6: While `osc_run_i` is low, supply transitions leave both snapshot sets unchanged.
- R7: From leaving `S_MAIN` until returning to it, host reads return 0x00, host writes have no effect, and `bus_rej_o` is high for any selected access.
- R8: Each supply edge gives exactly one capture. Later changes of the live time do not alter a stored snapshot.
- R9: A further power-down, taken while the flag is still set, overwrites the power-down set with the new time. The flag stays 1.
- R10: Snapshot bytes are read-only from the host. Reads of unmapped addresses return 0x00.
- R11: `on_batt_o` rises after the third rising clock edge that follows a fall of `supply_good_i`. It falls after the fourth rising edge that follows a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| supply_good_i | input | 1 | Asynchronous supply-good level from the comparator |
| osc_run_i | input | 1 | Oscillator-running flag from the clock core |
| min_i | input | 8 | Live minutes, BCD |
| hour_i | input | 8 | Live hours, BCD |
| date_i | input | 8 | Live date, BCD |
| month_i | input | 8 | Live month, BCD |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| bus_rej_o | output | 1 | Access refused while on backup power |
| batt_flag_o | output | 1 | Sticky battery-mode flag |
| on_batt_o | output | 1 | Sequencer is outside main-power operation |

## Verification
The bench builds the block with its default parameters. These are:
- a two-stage synchroniser,
- 8-bit addresses,
- snapshot bases at 0x18 and 0x1C,
- the flag at bit 4 of 0x03.

With these values the exact edge-to-state latency can be counted against the port timing. They also allow snapshots to be read back at their fixed addresses. The directed runs cover:
- repeated power cycles with the flag left set,
- a cycle with the oscillator stopped,
- writes attempted while on backup power,
- the clear write and the write of a set flag bit.

// File: rtl/pfts_pkg.sv
package pfts_pkg;

    localparam int STAMP_BYTES = 4;
    localparam int STAMP_SETS  = 2;

    typedef logic [STAMP_BYTES-1:0][7:0] stamp_t;

    typedef enum logic [1:0] {
        S_MAIN     = 2'd0,
        S_CAP_DOWN = 2'd1,
        S_BATT     = 2'd2,
        S_CAP_UP   = 2'd3
    } pf_state_t;

endpackage

// File: rtl/pfts_sync.sv
module pfts_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfts_seq.sv
module pfts_seq
    import pfts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sg_s_i,
    input  logic osc_run_i,
    output logic cap_down_o,
    output logic cap_up_o,
    output logic set_flag_o,
    output logic on_batt_o
);
    pf_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_MAIN;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_MAIN:     if (!sg_s_i) state_d = S_CAP_DOWN;
            S_CAP_DOWN: state_d = S_BATT;
            S_BATT:     if (sg_s_i)  state_d = S_CAP_UP;
            S_CAP_UP:   state_d = S_MAIN;
        endcase
    end

    // outputs
    always_comb begin
        cap_down_o = 1'b0;
        cap_up_o   = 1'b0;
        set_flag_o = 1'b0;
        on_batt_o  = 1'b1;
        unique case (state_q)
            S_MAIN:     on_batt_o = 1'b0;
            S_CAP_DOWN: begin
                cap_down_o = osc_run_i;
                set_flag_o = 1'b1;
            end
            S_BATT:     ;
            S_CAP_UP:   cap_up_o = osc_run_i;
        endcase
    end

    // R11 / R2: a low synchronised level on main power enters the capture state
    a_r11_fall_to_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MAIN && !sg_s_i) |=> (state_q == S_CAP_DOWN));

    // R4: a high synchronised level on backup enters the power-up capture
    a_r4_rise_to_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BATT && sg_s_i) |=> (state_q == S_CAP_UP));

    // R8: capture states last a single cycle
    a_r8_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CAP_DOWN) |=> (state_q == S_BATT));
endmodule

// File: rtl/pfts_regs.sv
module pfts_regs
    import pfts_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DOWN_BASE = 'h18,
    parameter int UP_BASE   = 'h1C,
    parameter int FLAG_ADDR = 'h03,
    parameter int FLAG_BIT  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  stamp_t                  live_i,
    input  logic                    cap_down_i,
    input  logic                    cap_up_i,
    input  logic                    set_flag_i,
    input  logic                    on_batt_i,
    input  logic                    bus_sel_i,
    input  logic                    bus_wr_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [7:0]              bus_wdata_i,
    output logic [7:0]              bus_rdata_o,
    output logic                    flag_o,
    output logic                    clr_o,
    output stamp_t [STAMP_SETS-1:0] stamps_o
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

    stamp_t [STAMP_SETS-1:0] stamp_q;
    logic [STAMP_SETS-1:0]   cap_vec;
    logic                    flag_q;
    logic                    host_ok;
    logic                    clr_evt;

    function automatic logic [ADDR_W-1:0] slot_addr(input int g, input int b);
        return ADDR_W'(((g == 0) ? DOWN_BASE : UP_BASE) + b);
    endfunction

    assign cap_vec = {cap_up_i, cap_down_i};
    assign host_ok = bus_sel_i && !on_batt_i;
    assign clr_evt = host_ok && bus_wr_i && (bus_addr_i == FLAG_A)
                     && !bus_wdata_i[FLAG_BIT];

    generate
        for (genvar g = 0; g < STAMP_SETS; g++) begin : g_set
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          stamp_q[g] <= '0;
                else if (clr_evt)    stamp_q[g] <= '0;
                else if (cap_vec[g]) stamp_q[g] <= live_i;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (set_flag_i) flag_q <= 1'b1;
        else if (clr_evt)    flag_q <= 1'b0;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (host_ok && !bus_wr_i) begin
            if (bus_addr_i == FLAG_A) bus_rdata_o[FLAG_BIT] = flag_q;
            for (int g = 0; g < STAMP_SETS; g++) begin
                for (int b = 0; b < STAMP_BYTES; b++) begin
                    if (bus_addr_i == slot_addr(g, b)) bus_rdata_o = stamp_q[g][b];
                end
            end
        end
    end

    assign flag_o   = flag_q;
    assign clr_o    = clr_evt;
    assign stamps_o = stamp_q;

    // R2/R4: never two captures at once
    a_r2_onehot_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_up_i, cap_down_i}));

    // R3: the sequencer's flag request shows up in the flag register
    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag_i |=> flag_q);

    // R5: a clearing write leaves flag and all snapshots zero
    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (!flag_q && stamp_q == '0));

    // R7: host writes on backup power never move the flag
    a_r7_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (on_batt_i && bus_sel_i && bus_wr_i && !set_flag_i) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/pwr_stamp_top.sv
module pwr_stamp_top
    import pfts_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter int DOWN_BASE   = 'h18,
    parameter int UP_BASE     = 'h1C,
    parameter int FLAG_ADDR   = 'h03,
    parameter int FLAG_BIT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_good_i,
    input  logic              osc_run_i,
    input  logic [7:0]        min_i,
    input  logic [7:0]        hour_i,
    input  logic [7:0]        date_i,
    input  logic [7:0]        month_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              bus_rej_o,
    output logic              batt_flag_o,
    output logic              on_batt_o
);
    logic                    sg_s;
    logic                    cap_down, cap_up, set_flag, on_batt;
    logic                    clr_evt;
    stamp_t                  live;
    stamp_t [STAMP_SETS-1:0] stamps;

    assign live = {month_i, date_i, hour_i, min_i};

    pfts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (supply_good_i),
        .q_o   (sg_s)
    );

    pfts_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sg_s_i     (sg_s),
        .osc_run_i  (osc_run_i),
        .cap_down_o (cap_down),
        .cap_up_o   (cap_up),
        .set_flag_o (set_flag),
        .on_batt_o  (on_batt)
    );

    pfts_regs #(
        .ADDR_W    (ADDR_W),
        .DOWN_BASE (DOWN_BASE),
        .UP_BASE   (UP_BASE),
        .FLAG_ADDR (FLAG_ADDR),
        .FLAG_BIT  (FLAG_BIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .live_i      (live),
        .cap_down_i  (cap_down),
        .cap_up_i    (cap_up),
        .set_flag_i  (set_flag),
        .on_batt_i   (on_batt),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .flag_o      (batt_flag_o),
        .clr_o       (clr_evt),
        .stamps_o    (stamps)
    );

    assign on_batt_o = on_batt;
    assign bus_rej_o = bus_sel_i && on_batt;

    // R6: with the oscillator stopped and no clear, snapshots hold
    a_r6_hold_without_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run_i && !clr_evt) |=> (stamps == $past(stamps)));

    // R7: a refused access never returns data
    a_r7_reads_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rej_o |-> (bus_rdata_o == 8'h00));
endmodule

// File: tb/pwr_stamp_top_test.sv
module pwr_stamp_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_good_i = 1'b1;
    logic       osc_run_i = 1'b1;
    logic [7:0] min_i = 8'h00, hour_i = 8'h00, date_i = 8'h01, month_i = 8'h01;
    logic       bus_sel_i = 1'b0, bus_wr_i = 1'b0;
    logic [7:0] bus_addr_i = 8'h00, bus_wdata_i = 8'h00;
    logic [7:0] bus_rdata_o;
    logic       bus_rej_o, batt_flag_o, on_batt_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    pwr_stamp_top uut (
        .clk(clk), .rst_n(rst_n), .supply_good_i(supply_good_i), .osc_run_i(osc_run_i),
        .min_i(min_i), .hour_i(hour_i), .date_i(date_i), .month_i(month_i),
        .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .bus_rej_o(bus_rej_o),
        .batt_flag_o(batt_flag_o), .on_batt_o(on_batt_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_time(input logic [7:0] mi, input logic [7:0] hr,
                            input logic [7:0] dt, input logic [7:0] mo);
        @(negedge clk);
        min_i = mi; hour_i = hr; date_i = dt; month_i = mo;
    endtask

    task automatic rd(input logic [7:0] addr, output logic [7:0] data, output logic rej);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = addr;
        #1;
        data = bus_rdata_o;
        rej  = bus_rej_o;
        bus_sel_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = addr; bus_wdata_i = data;
        @(posedge clk);
        #1;
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic chk_set(input string tag, input logic [7:0] base,
                           input logic [7:0] mi, input logic [7:0] hr,
                           input logic [7:0] dt, input logic [7:0] mo);
        logic [7:0] d;
        logic       r;
        rd(base,     d, r); check({tag, " minutes"}, d, mi);
        rd(base + 1, d, r); check({tag, " hours"},   d, hr);
        rd(base + 2, d, r); check({tag, " date"},    d, dt);
        rd(base + 3, d, r); check({tag, " month"},   d, mo);
    endtask

    task automatic power_down();
        @(negedge clk);
        supply_good_i = 1'b0;
        repeat (5) @(posedge clk);
    endtask

    task automatic power_up();
        @(negedge clk);
        supply_good_i = 1'b1;
        repeat (5) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic       r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 flag after reset", {7'b0, batt_flag_o}, 8'h00);
        check("R1 on_batt after reset", {7'b0, on_batt_o}, 8'h00);
        for (int a = 8'h18; a <= 8'h1F; a++) begin
            rd(8'(a), d, r);
            check("R1 snapshot zero", d, 8'h00);
        end
    endtask

    task automatic t_cycle_basic();
        logic [7:0] d;
        logic       r;
        set_time(8'h45, 8'h13, 8'h27, 8'h08);
        @(negedge clk);
        supply_good_i = 1'b0;
        repeat (2) @(posedge clk);
        #1 check("R11 on_batt not yet", {7'b0, on_batt_o}, 8'h00);
        @(posedge clk);
        #1 check("R11 on_batt after third edge", {7'b0, on_batt_o}, 8'h01);
        repeat (3) @(posedge clk);
        rd(8'h18, d, r);
        check("R7 read on battery is zero", d, 8'h00);
        check("R7 reject on battery", {7'b0, r}, 8'h01);
        wr(8'h03, 8'h00);
        set_time(8'h02, 8'h14, 8'h27, 8'h08);
        @(negedge clk);
        supply_good_i = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R11 on_batt still high", {7'b0, on_batt_o}, 8'h01);
        @(posedge clk);
        #1 check("R11 on_batt low after fourth edge", {7'b0, on_batt_o}, 8'h00);
        check("R7 flag survived blocked clear", {7'b0, batt_flag_o}, 8'h01);
        rd(8'h03, d, r);
        check("R3 flag reads 0x10", d, 8'h10);
        set_time(8'h59, 8'h23, 8'h31, 8'h12);
        chk_set("R2 R8 down set", 8'h18, 8'h45, 8'h13, 8'h27, 8'h08);
        chk_set("R4 R8 up set",   8'h1C, 8'h02, 8'h14, 8'h27, 8'h08);
    endtask

    task automatic t_readonly();
        logic [7:0] d;
        logic       r;
        wr(8'h18, 8'h99);
        wr(8'h1F, 8'h77);
        rd(8'h18, d, r); check("R10 down minutes read-only", d, 8'h45);
        rd(8'h1F, d, r); check("R10 up month read-only", d, 8'h08);
        rd(8'h40, d, r); check("R10 unmapped reads zero", d, 8'h00);
        check("R10 no reject on main", {7'b0, r}, 8'h00);
    endtask

    task automatic t_flag_one();
        wr(8'h03, 8'hFF);
        #1 check("R5 set-bit write keeps flag", {7'b0, batt_flag_o}, 8'h01);
        chk_set("R5 set-bit write keeps down set", 8'h18, 8'h45, 8'h13, 8'h27, 8'h08);
    endtask

    task automatic t_redown();
        set_time(8'h10, 8'h06, 8'h15, 8'h03);
        power_down();
        set_time(8'h20, 8'h07, 8'h15, 8'h03);
        power_up();
        #1 check("R9 flag stays set", {7'b0, batt_flag_o}, 8'h01);
        chk_set("R9 down set overwritten", 8'h18, 8'h10, 8'h06, 8'h15, 8'h03);
        chk_set("R4 up set second cycle", 8'h1C, 8'h20, 8'h07, 8'h15, 8'h03);
    endtask

    task automatic t_no_osc();
        @(negedge clk);
        osc_run_i = 1'b0;
        wr(8'h03, 8'h00);
        #1 check("R5 clear before no-osc run", {7'b0, batt_flag_o}, 8'h00);
        set_time(8'h33, 8'h11, 8'h04, 8'h05);
        power_down();
        power_up();
        #1 check("R3 flag set without oscillator", {7'b0, batt_flag_o}, 8'h01);
        chk_set("R6 down held without osc", 8'h18, 8'h00, 8'h00, 8'h00, 8'h00);
        chk_set("R6 up held without osc",   8'h1C, 8'h00, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        osc_run_i = 1'b1;
        set_time(8'h41, 8'h09, 8'h04, 8'h05);
        power_down();
        power_up();
        chk_set("R2 capture with osc back", 8'h18, 8'h41, 8'h09, 8'h04, 8'h05);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        logic       r;
        wr(8'h03, 8'hEF);
        #1 check("R5 flag cleared", {7'b0, batt_flag_o}, 8'h00);
        for (int a = 8'h18; a <= 8'h1F; a++) begin
            rd(8'(a), d, r);
            check("R5 snapshot cleared", d, 8'h00);
        end
        rd(8'h03, d, r);
        check("R5 flag register reads zero", d, 8'h00);
    endtask

    initial begin
        t_reset();
        t_cycle_basic();
        t_readonly();
        t_flag_one();
        t_redown();
        t_no_osc();
        t_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule